// File: doc/BRIEF.md
# Dead-Band Complementary Output Generator

This block takes one of two incoming PWM waveforms and turns it into a pair of complementary output legs. Dead time is inserted between the two legs. The first leg turns on only after the source has been high for a programmable number of clock cycles. The second leg turns on only after the source has been low for a separate programmable number of cycles. Because of this, the two legs are never on at the same time. Each leg can be turned off after one clock edge, as soon as the source leaves the state that drives it.

A two-bit edge mode selects whether each of the two delays is applied. A delay that is not applied, or a delay count of zero, makes that leg follow the source after a single register stage. A two-bit inversion code can flip either leg, both legs, or neither leg at the pins.

Each leg takes its delay value and its mode setting at the source edge that starts it. A configuration write during a delay in progress therefore does not disturb that delay.

Top module: `deadband_pair`

## Requirements
- R1: The source is `pwm_a` when `cfg_src` is 0 and `pwm_b` when `cfg_src` is 1; the unselected input has no effect on the outputs.
- R2: While `rst_n` is low, both legs before inversion are low, so `out_a` equals `cfg_inv[0]` and `out_b` equals `cfg_inv[1]`.
- R3: Let N be the applied rise delay. If the source is sampled high at N+1 consecutive rising clock edges, the first leg before inversion goes high after the (N+1)th edge and stays high while the source stays high.
- R4: Let M be the applied fall delay. If the source is sampled low at M+1 consecutive edges, the second leg before inversion goes high after the (M+1)th edge and stays high while the source stays low.
- R5: Edge mode bit 1 enables the rise delay and bit 0 enables the fall delay. Code 00 applies no delay, 01 applies only the fall delay, 10 applies only the rise delay, and 11 applies both. A delay that is not enabled counts as 0.
- R6: A delay count of 0 behaves exactly like a disabled delay: the leg follows after one edge.
- R7: A source pulse or gap shorter than the pending delay cancels the pending turn-on, and that leg produces no pulse.
- R8: `cfg_inv` bit 0 inverts `out_a` and bit 1 inverts `out_b`. Code 0 inverts neither leg, 1 inverts only `out_a`, 2 inverts only `out_b`, and 3 inverts both.
- R9: The two legs before inversion are never high in the same cycle.
- R10: The delay value and mode for a leg are captured at the source edge that starts that leg. Later changes to them do not alter a delay that is already counting.
- R11: A leg before inversion is low after any edge at which the source was sampled in the opposite state to the one that drives that leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a | input | 1 | PWM input selected when cfg_src is 0 |
| pwm_b | input | 1 | PWM input selected when cfg_src is 1 |
| cfg_src | input | 1 | Source select |
| cfg_edge_mode | input | 2 | Delay enable code: bit 1 enables the rise delay, bit 0 enables the fall delay |
| cfg_inv | input | 2 | Per-leg inversion code |
| cfg_rise_dly | input | 16 | Rise delay in clock cycles |
| cfg_fall_dly | input | 16 | Fall delay in clock cycles |
| out_a | output | 1 | First leg, delayed on the source's rising edge |
| out_b | output | 1 | Second leg, delayed on the source's falling edge |

## Verification
The assertions assume that the PWM inputs are already synchronous to `clk`, so each edge check sees one clean sampled value per cycle. They also assume that the configuration inputs are stable around each clock edge. The stimulus changes every input only on the falling clock edge. It holds each source level for whole cycles, and it changes configuration mid-delay only in the directed test that targets edge-time capture. Pulse and gap lengths are kept both above and below the programmed delays, so that both completed and cancelled turn-ons are exercised.

// File: rtl/deadband_pair.sv
module deadband_pair #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_a,
  input  logic          pwm_b,
  input  logic          cfg_src,
  input  logic [1:0]    cfg_edge_mode,
  input  logic [1:0]    cfg_inv,
  input  logic [DW-1:0] cfg_rise_dly,
  input  logic [DW-1:0] cfg_fall_dly,
  output logic          out_a,
  output logic          out_b
);

  logic          src;
  logic [1:0]    leg_in, leg_prev, leg_on, leg_use;
  logic [DW-1:0] leg_req [2];
  logic [DW-1:0] leg_eff [2];
  logic [DW-1:0] leg_cnt [2];
  logic [DW-1:0] leg_dly [2];

  assign src        = cfg_src ? pwm_b : pwm_a;
  assign leg_in     = {~src, src};
  assign leg_use    = {cfg_edge_mode[0], cfg_edge_mode[1]};
  assign leg_req[0] = cfg_rise_dly;
  assign leg_req[1] = cfg_fall_dly;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    assign leg_eff[g] = leg_use[g] ? leg_req[g] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        leg_prev[g] <= 1'b0;
        leg_on[g]   <= 1'b0;
        leg_cnt[g]  <= '0;
        leg_dly[g]  <= '0;
      end else begin
        leg_prev[g] <= leg_in[g];
        if (!leg_in[g]) begin
          leg_on[g]  <= 1'b0;
          leg_cnt[g] <= '0;
        end else if (!leg_prev[g]) begin
          leg_dly[g] <= leg_eff[g];
          if (leg_eff[g] == '0) begin
            leg_on[g]  <= 1'b1;
            leg_cnt[g] <= '0;
          end else begin
            leg_cnt[g] <= DW'(1);
          end
        end else if (!leg_on[g]) begin
          if (leg_cnt[g] == leg_dly[g]) leg_on[g] <= 1'b1;
          else leg_cnt[g] <= leg_cnt[g] + DW'(1);
        end
      end
    end

    // R11: a leg is off whenever its driving level was absent at the last edge
    a_r11_off_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !leg_prev[g] |-> !leg_on[g]);
    // R3 and R4: the counter never runs past the captured delay
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      leg_cnt[g] <= leg_dly[g]);
    // R6: a zero delay turns the leg on after a single edge
    a_r6_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_in[g] && !leg_prev[g] && leg_eff[g] == '0) |=> leg_on[g]);
    // R7: the leg turns on only once the full delay has elapsed
    a_r7_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(leg_on[g]) |-> (leg_cnt[g] == leg_dly[g]));
  end

  // R9: the legs before inversion never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_on[0] && leg_on[1]));

  assign out_a = leg_on[0] ^ cfg_inv[0];
  assign out_b = leg_on[1] ^ cfg_inv[1];

endmodule

// File: tb/sim_deadband_pair.sv
`timescale 1ns/1ps
module sim_deadband_pair;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_a = 1'b0, pwm_b = 1'b1, cfg_src = 1'b0;
  logic [1:0] cfg_edge_mode = 2'b11, cfg_inv = 2'b10;
  logic [15:0] cfg_rise_dly = '0, cfg_fall_dly = '0;
  logic out_a, out_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  deadband_pair u0 (.clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cfg_src(cfg_src), .cfg_edge_mode(cfg_edge_mode), .cfg_inv(cfg_inv),
    .cfg_rise_dly(cfg_rise_dly), .cfg_fall_dly(cfg_fall_dly),
    .out_a(out_a), .out_b(out_b));

  typedef struct packed {
    logic        sel;
    logic [1:0]  mode;
    logic [1:0]  inv;
    logic [15:0] rise;
    logic [15:0] fall;
    logic [7:0]  hi;
    logic [7:0]  lo;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'b11, 2'b00, 16'd3,  16'd2,  8'd8,  8'd7},
    '{1'b1, 2'b11, 2'b01, 16'd4,  16'd6,  8'd10, 8'd10},
    '{1'b0, 2'b00, 2'b00, 16'd5,  16'd5,  8'd6,  8'd6},
    '{1'b1, 2'b01, 2'b10, 16'd7,  16'd3,  8'd9,  8'd8},
    '{1'b0, 2'b10, 2'b11, 16'd2,  16'd9,  8'd6,  8'd5},
    '{1'b0, 2'b11, 2'b00, 16'd0,  16'd0,  8'd4,  8'd4},
    '{1'b1, 2'b11, 2'b00, 16'd12, 16'd3,  8'd5,  8'd6},
    '{1'b0, 2'b11, 2'b01, 16'd1,  16'd15, 8'd7,  8'd9}
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive_src(input logic v);
    if (cfg_src) begin pwm_b = v; pwm_a = ~v; end
    else begin pwm_a = v; pwm_b = ~v; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs show only the inversion code during reset
    check("R2 reset", {out_b, out_a}, 2'b10);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      vec_t v = VECS[i];
      int n = v.mode[1] ? int'(v.rise) : 0;
      int m = v.mode[0] ? int'(v.fall) : 0;
      int mis = 0, ovl = 0;
      logic [1:0] fa = 2'b00, fe = 2'b00;
      cfg_src = v.sel; cfg_edge_mode = v.mode; cfg_inv = v.inv;
      cfg_rise_dly = v.rise; cfg_fall_dly = v.fall;
      drive_src(1'b1);
      for (int k = 1; k <= int'(v.hi); k++) begin
        logic e0;
        @(negedge clk);
        e0 = (k > n);
        if ((out_a ^ v.inv[0]) && (out_b ^ v.inv[1])) ovl++;
        if (out_a !== (e0 ^ v.inv[0]) || out_b !== v.inv[1]) begin
          if (mis == 0) begin fa = {out_b, out_a}; fe = {v.inv[1], e0 ^ v.inv[0]}; end
          mis++;
        end
      end
      drive_src(1'b0);
      for (int k = 1; k <= int'(v.lo); k++) begin
        logic e1;
        @(negedge clk);
        e1 = (k > m);
        if ((out_a ^ v.inv[0]) && (out_b ^ v.inv[1])) ovl++;
        if (out_a !== v.inv[0] || out_b !== (e1 ^ v.inv[1])) begin
          if (mis == 0) begin fa = {out_b, out_a}; fe = {e1 ^ v.inv[1], v.inv[0]}; end
          mis++;
        end
      end
      // R1 R3 R4 R5 R6 R7 R8 R11: whole waveform of the entry
      check($sformatf("R1/R3/R4/R5/R6/R7/R8/R11 vec%0d first-mismatch", i), fa, fe);
      // R9: no overlap of legs before inversion
      check($sformatf("R9 vec%0d overlap-count", i), 2'(ovl > 0), 2'b00);
    end

    // R10: configuration change mid-delay does not alter the running count
    cfg_src = 1'b0; cfg_inv = 2'b00; cfg_edge_mode = 2'b11;
    cfg_rise_dly = 16'd5; cfg_fall_dly = 16'd2;
    repeat (5) @(negedge clk);
    drive_src(1'b1);
    repeat (2) @(negedge clk);
    cfg_rise_dly = 16'd1; cfg_edge_mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 still waiting at k=5", {out_b, out_a}, 2'b00);
    @(negedge clk);
    check("R10 on at k=6", {out_b, out_a}, 2'b01);

    // R1: toggling the unselected input has no effect
    pwm_b = 1'b0; @(negedge clk); pwm_b = 1'b1; @(negedge clk);
    check("R1 unselected input ignored", {out_b, out_a}, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule